// File: doc/BRIEF.md
# Memory Refresh Counter

This block holds the refresh register of an 8-bit microprocessor core that is compatible with the classic instruction set. The core pulses one strobe on every opcode fetch and treats each prefix byte as a fetch of its own. It pulses a second strobe on each repeat of a block-transfer instruction. The register counts those events in its low 7 bits, which gives a row address for a 128-row dynamic memory. Bit 7 is never touched by counting.

The core can also write the register from its accumulator and read it back. During the refresh phase of a fetch, the block places a refresh address on its output: the interrupt-vector byte supplied by the core sits above the 7-bit row count. Instruction decoding and memory timing are left to the core.

Top module: `rfsh_counter`

## Requirements
- R1: While the reset is active, and until the synchronised release takes effect, the register reads 0x00.
- R2: A cycle with `fetch_stb` high, `rpt_stb` low and `load_en` low adds 1 to bits 6:0 of `r_val`.
- R3: A cycle with `rpt_stb` high and `load_en` low adds 2 to bits 6:0. If `fetch_stb` is also high in that cycle, the sum is 3.
- R4: Bits 6:0 wrap modulo 128. For example, 0x7F plus 1 becomes 0x00, and 0xFF plus 1 becomes 0x80.
- R5: Bit 7 of `r_val` changes only in a cycle with `load_en` high.
- R6: `load_en` writes all 8 bits of `load_data`. It takes priority over both strobes in the same cycle.
- R7: A cycle with no strobe and no load leaves `r_val` unchanged.
- R8: While `rfsh_phase` is high, `rfsh_addr` equals {`i_val`, `r_val[6:0]`}, with `i_val` in bits 14:7. While `rfsh_phase` is low, `rfsh_addr` is zero.
- R9: A single-prefixed instruction gives two fetch strobes, so the register advances by 2. A doubly prefixed bit instruction also gives only two fetch strobes and advances by 2. Loading value V and then executing a two-byte read gives V with bits 6:0 increased by 2 and bit 7 kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fetch_stb | input | 1 | One opcode or prefix fetch in this cycle |
| rpt_stb | input | 1 | One repeat iteration of a block instruction in this cycle |
| load_en | input | 1 | Write `load_data` into the register |
| load_data | input | 8 | Value to load |
| rfsh_phase | input | 1 | Refresh phase of the current fetch |
| i_val | input | 8 | Interrupt-vector byte, forming the upper part of the refresh address |
| r_val | output | 8 | Current register value |
| rfsh_addr | output | 15 | Refresh address, {i_val, r_val[6:0]} |

## Verification
The assertions assume that the strobes and the load are sampled once per clock. They also assume that nothing is counted before the internal reset release. The stimulus therefore changes inputs only on the falling edge, and it holds every strobe low until several cycles after reset is released. Random cycles mix loads, single and combined strobes and idle cycles. Directed runs cover the row wrap with bit 7 both clear and set, prefixed and repeating instruction patterns, and a load that lands together with both strobes.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int ROW_W = 7;
  localparam int R_W   = ROW_W + 1;
  localparam int I_W   = 8;
  localparam int ADDR_W = I_W + ROW_W;
  typedef logic [R_W-1:0]   r_t;
  typedef logic [ROW_W-1:0] row_t;
endpackage

// File: rtl/rfsh_rst_sync.sv
module rfsh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rfsh_step.sv
module rfsh_step
  import rfsh_pkg::*;
(
  input  r_t   r_cur,
  input  logic fetch_stb,
  input  logic rpt_stb,
  input  logic load_en,
  input  r_t   load_data,
  output r_t   r_next,
  output logic r_en
);
  row_t inc;

  always_comb begin
    inc = row_t'({1'b0, rpt_stb, fetch_stb});
    r_en = load_en | fetch_stb | rpt_stb;
    if (load_en) r_next = load_data;
    else         r_next = {r_cur[R_W-1], r_cur[ROW_W-1:0] + inc};
  end
endmodule

// File: rtl/rfsh_reg.sv
module rfsh_reg
  import rfsh_pkg::*;
(
  input  logic clk,
  input  logic rst_sync_n,
  input  logic r_en,
  input  r_t   r_next,
  input  logic fetch_stb,
  input  logic rpt_stb,
  input  logic load_en,
  input  r_t   load_data,
  output r_t   r_q
);
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  r_q <= '0;
    else if (r_en)    r_q <= r_next;
  end

  // R5
  msb_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !load_en |=> $stable(r_q[R_W-1]));
  // R6
  load_prio_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_en |=> r_q == $past(load_data));
  // R2
  fetch_inc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_stb && !rpt_stb && !load_en) |=>
      r_q[ROW_W-1:0] == row_t'($past(r_q[ROW_W-1:0]) + row_t'(1)));
  // R3
  rpt_inc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rpt_stb && !fetch_stb && !load_en) |=>
      r_q[ROW_W-1:0] == row_t'($past(r_q[ROW_W-1:0]) + row_t'(2)));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rpt_stb && !fetch_stb && !load_en) |=> $stable(r_q));
endmodule

// File: rtl/rfsh_counter.sv
module rfsh_counter
  import rfsh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_stb,
  input  logic              rpt_stb,
  input  logic              load_en,
  input  logic [R_W-1:0]    load_data,
  input  logic              rfsh_phase,
  input  logic [I_W-1:0]    i_val,
  output logic [R_W-1:0]    r_val,
  output logic [ADDR_W-1:0] rfsh_addr
);
  logic rst_sync_n;
  r_t   r_q, r_next;
  logic r_en;

  rfsh_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  rfsh_step u_step (
    .r_cur(r_q), .fetch_stb(fetch_stb), .rpt_stb(rpt_stb),
    .load_en(load_en), .load_data(load_data),
    .r_next(r_next), .r_en(r_en));

  rfsh_reg u_reg (
    .clk(clk), .rst_sync_n(rst_sync_n), .r_en(r_en), .r_next(r_next),
    .fetch_stb(fetch_stb), .rpt_stb(rpt_stb), .load_en(load_en),
    .load_data(load_data), .r_q(r_q));

  assign r_val     = r_q;
  assign rfsh_addr = rfsh_phase ? {i_val, r_q[ROW_W-1:0]} : '0;

  // R8
  rfsh_row_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rfsh_phase |-> rfsh_addr[ROW_W-1:0] == r_val[ROW_W-1:0]);
endmodule

// File: tb/rfsh_counter_bench.sv
module rfsh_counter_bench;
  logic clk, rst_n, fetch_stb, rpt_stb, load_en, rfsh_phase;
  logic [7:0] load_data, i_val, r_val;
  logic [14:0] rfsh_addr;
  logic [7:0] r_exp;
  int tests, fails;

  rfsh_counter u_rfsh_counter (
    .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .rpt_stb(rpt_stb),
    .load_en(load_en), .load_data(load_data), .rfsh_phase(rfsh_phase),
    .i_val(i_val), .r_val(r_val), .rfsh_addr(rfsh_addr));

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic logic [7:0] model(logic [7:0] r, logic f, logic rp,
                                        logic ld, logic [7:0] d);
    logic [6:0] lo;
    if (ld) return d;
    lo = r[6:0] + 7'(f) + 7'({rp, 1'b0});
    return {r[7], lo};
  endfunction

  task automatic check(string req, logic [14:0] act, logic [14:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic f, logic rp, logic ld, logic [7:0] d,
                     logic ph, logic [7:0] iv, string req);
    fetch_stb = f; rpt_stb = rp; load_en = ld; load_data = d;
    rfsh_phase = ph; i_val = iv;
    r_exp = model(r_exp, f, rp, ld, d);
    @(posedge clk); #1;
    check(req, {7'd0, r_val}, {7'd0, r_exp});
    check("R8", rfsh_addr, ph ? {iv, r_exp[6:0]} : 15'd0);
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    tests = 0; fails = 0;
    rst_n = 0; fetch_stb = 0; rpt_stb = 0; load_en = 0;
    load_data = 8'hA5; rfsh_phase = 0; i_val = 0;
    repeat (3) @(negedge clk);
    check("R1", {7'd0, r_val}, 15'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", {7'd0, r_val}, 15'd0);
    r_exp = 8'h00;

    cyc(1, 0, 0, 8'h00, 1, 8'h3C, "R2");
    cyc(0, 1, 0, 8'h00, 0, 8'h00, "R3");
    cyc(1, 1, 0, 8'h00, 1, 8'hC3, "R3");
    cyc(0, 0, 0, 8'h00, 1, 8'h11, "R7");
    cyc(0, 0, 1, 8'h7E, 0, 8'h00, "R6");
    cyc(1, 0, 0, 8'h00, 0, 8'h00, "R2");
    cyc(1, 0, 0, 8'h00, 0, 8'h00, "R4");
    if (r_val !== 8'h00) begin fails++; $display("FAIL R4 actual=%h expected=00", r_val); end
    tests++;
    cyc(0, 0, 1, 8'hFF, 0, 8'h00, "R6");
    cyc(1, 0, 0, 8'h00, 1, 8'hFF, "R4");
    if (r_val !== 8'h80) begin fails++; $display("FAIL R5 actual=%h expected=80", r_val); end
    tests++;
    cyc(1, 1, 1, 8'h12, 0, 8'h00, "R6");
    cyc(0, 0, 1, 8'hFF, 0, 8'h00, "R6");
    cyc(0, 1, 0, 8'h00, 0, 8'h00, "R4");
    cyc(1, 1, 0, 8'h00, 0, 8'h00, "R5");
    // R9: load, then a two-byte read instruction
    cyc(0, 0, 1, 8'hC4, 0, 8'h00, "R9");
    cyc(1, 0, 0, 8'h00, 0, 8'h00, "R9");
    cyc(1, 0, 0, 8'h00, 0, 8'h00, "R9");
    if (r_val !== 8'hC6) begin fails++; $display("FAIL R9 actual=%h expected=C6", r_val); end
    tests++;
    // R9: doubly prefixed bit op, two fetches, two non-fetch bytes
    cyc(1, 0, 0, 8'h00, 0, 8'h00, "R9");
    cyc(1, 0, 0, 8'h00, 0, 8'h00, "R9");
    cyc(0, 0, 0, 8'h00, 0, 8'h00, "R9");
    cyc(0, 0, 0, 8'h00, 0, 8'h00, "R9");
    if (r_val !== 8'hC8) begin fails++; $display("FAIL R9 actual=%h expected=C8", r_val); end
    tests++;
    // repeating block transfer: two fetches then four repeats
    cyc(1, 0, 0, 8'h00, 0, 8'h00, "R3");
    cyc(1, 0, 0, 8'h00, 0, 8'h00, "R3");
    for (int k = 0; k < 4; k++) cyc(0, 1, 0, 8'h00, 1, 8'h40, "R3");
    if (r_val !== 8'hD2) begin fails++; $display("FAIL R3 actual=%h expected=D2", r_val); end
    tests++;

    for (int n = 0; n < 3000; n++) begin
      logic f, rp, ld;
      string req;
      f  = ($urandom % 3) != 0;
      rp = ($urandom % 4) == 0;
      ld = ($urandom % 8) == 0;
      req = ld ? "R6" : (rp ? "R3" : (f ? "R2" : "R7"));
      if (!ld && r_exp[7]) req = "R5";
      cyc(f, rp, ld, 8'($urandom), 1'($urandom), 8'($urandom), req);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule